// File: doc/BRIEF.md
# Periodic Tick Timer

This block produces a recurring event flag from the free-running oscillator clock. Software loads a 7-bit setting through a one-cycle write strobe. The upper three bits choose a power-of-two divider and the lower four bits choose a whole-number multiplier on top of it. At the end of every period a sticky flag is raised and the next period begins with no gap. When the interrupt enable is set, the flag is forwarded as an interrupt request.

Any write to the setting restarts the period from zero. Software can therefore use a periodic rewrite as a watchdog-style keep-alive tick. Two low-power gating inputs control the counting. In the first, wait mode combined with its stop option halts the dividers and reinitialises them. In the second, pseudo-stop mode freezes them unless its run option is set. The parameter `EXP_BASE` sets the base divider exponent. It defaults to 9 and can be lowered so that simulation needs fewer cycles.

Top module: `rtick_timer`

## Requirements
- R1: A high `cfg_wr` loads `cfg_wdata` into the setting register. Bits [6:4] are the prescale code and bits [3:0] are the modulus. After reset the setting is 0, the flag is 0 and the interrupt enable is 0.
- R2: For a prescale code p from 1 to 7 and a modulus m, the period is (m+1)·2^(EXP_BASE+p) clock cycles. With EXP_BASE=1, a setting of 0x1F gives 64 cycles and 0x27 gives 64 cycles.
- R3: A prescale code of 0 disables the timer. The flag is never set and the dividers are held at zero.
- R4: A write to the setting restarts counting from zero. The flag is set exactly one full period after the write edge. A period end that falls in the same cycle as a write is discarded.
- R5: While the timer runs, the flag is set again every period, with no lost cycles between periods.
- R6: A cycle with `stat_wr`=1 and `stat_wdata`=1 clears the flag. A cycle with `stat_wr`=1 and `stat_wdata`=0 has no effect on it.
- R7: If a period ends in the same cycle as a clear, the flag stays set.
- R8: `ien_wr` loads `ien_wdata` into the interrupt enable. `irq_o` is high exactly when both the flag and the enable are 1.
- R9: While `wait_mode` and `wait_stop_en` are both 1, the dividers are held at zero. A full period follows the release. With `wait_stop_en`=0, wait mode has no effect.
- R10: While `pstop_mode`=1 and `pstop_run_en`=0, the dividers freeze and later resume where they stopped. With `pstop_run_en`=1, pseudo-stop mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; also the count source |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Setting write strobe |
| cfg_wdata | input | 7 | Setting value: prescale [6:4], modulus [3:0] |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 1 | Write 1 to clear the flag |
| ien_wr | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 1 | New interrupt enable value |
| wait_mode | input | 1 | Chip is in wait mode |
| wait_stop_en | input | 1 | Stop and reinitialise the timer in wait mode |
| pstop_mode | input | 1 | Chip is in pseudo-stop mode |
| pstop_run_en | input | 1 | Keep counting in pseudo-stop mode |
| flag_o | output | 1 | Sticky period-end flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situations to reach from the ports are those where two events meet in a single cycle. One is a period end in the same cycle as a flag clear. The other is a period end in the same cycle as a setting write. The bench measures the period in cycles with the parameter lowered, so every later period boundary falls on a known cycle. It then places the clear or the rewrite exactly on that cycle. The freeze case is reached the same way: the bench stops the count partway through a period and checks that the cycles remaining after release equal the unfinished part of that period.

// File: rtl/rtick_pkg.sv
// Shared widths and the setting layout for the periodic tick timer.
package rtick_pkg;
    localparam int unsigned PRE_W = 3;
    localparam int unsigned MOD_W = 4;
    localparam int unsigned CFG_W = PRE_W + MOD_W;

    // Setting register: prescale code in the upper bits, modulus below.
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [MOD_W-1:0] modv;
    } rtick_cfg_t;
endpackage

// File: rtl/rtick_prescaler.sv
// Power-of-two divider. Counts advance cycles up to 2^(EXP_BASE+pre)-1
// and emits a terminal pulse on the last one. Assumes pre is nonzero
// whenever adv is high; clr has priority over adv.
module rtick_prescaler #(
    parameter int unsigned EXP_BASE = 9,
    parameter int unsigned PRE_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [PRE_W-1:0] pre,
    output logic             tc
);
    localparam int unsigned MAXP = (1 << PRE_W) - 1;
    localparam int unsigned CW   = EXP_BASE + MAXP;

    logic [CW-1:0]    cnt;
    logic [CW-1:0]    lim;
    logic [PRE_W-1:0] sh;

    // Terminal count for the selected exponent: all ones in the low bits.
    always_comb begin
        sh  = PRE_W'(MAXP) - pre;
        lim = {CW{1'b1}} >> sh;
        tc  = adv && (cnt == lim);
    end

    // Divider state: cleared on request, wraps at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= tc ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rtick_modcnt.sv
// Modulus stage. Counts prescaler pulses from 0 to modv and flags the
// pulse that completes a period. clr has priority over step.
module rtick_modcnt #(
    parameter int unsigned MOD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [MOD_W-1:0] modv,
    output logic             wrap
);
    logic [MOD_W-1:0] cnt;

    // Period completes on the step that arrives while at the modulus.
    always_comb wrap = step && (cnt == modv);

    // Modulus counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rtick_flag.sv
// Sticky event flag with write-1-to-clear. A set in the same cycle as a
// clear wins, so no event is lost.
module rtick_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Flag state: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (clr) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/rtick_timer.sv
// Periodic tick timer top. Holds the setting and the interrupt enable,
// decides when the divider chain runs, freezes or restarts, and raises
// the flag and interrupt. Assumes all inputs are synchronous to clk,
// which is the oscillator clock that is counted.
module rtick_timer #(
    parameter int unsigned EXP_BASE = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr,
    input  logic [rtick_pkg::CFG_W-1:0] cfg_wdata,
    input  logic                       stat_wr,
    input  logic                       stat_wdata,
    input  logic                       ien_wr,
    input  logic                       ien_wdata,
    input  logic                       wait_mode,
    input  logic                       wait_stop_en,
    input  logic                       pstop_mode,
    input  logic                       pstop_run_en,
    output logic                       flag_o,
    output logic                       irq_o
);
    import rtick_pkg::*;

    rtick_cfg_t cfg_q;
    logic       ien_q;
    logic       halt_wait;
    logic       halt_pstop;
    logic       enabled;
    logic       div_clr;
    logic       div_adv;
    logic       presc_tc;
    logic       period_end;
    logic       flag_clr;

    // Setting and enable registers written by their strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            ien_q <= 1'b0;
        end else begin
            if (cfg_wr) cfg_q <= rtick_cfg_t'(cfg_wdata);
            if (ien_wr) ien_q <= ien_wdata;
        end
    end

    // Run control: reinitialise, freeze or advance the divider chain.
    always_comb begin
        enabled    = (cfg_q.pre != '0);
        halt_wait  = wait_mode && wait_stop_en;
        halt_pstop = pstop_mode && !pstop_run_en;
        div_clr    = cfg_wr || !enabled || halt_wait;
        div_adv    = enabled && !cfg_wr && !halt_wait && !halt_pstop;
        flag_clr   = stat_wr && stat_wdata;
    end

    rtick_prescaler #(
        .EXP_BASE (EXP_BASE),
        .PRE_W    (PRE_W)
    ) presc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_clr),
        .adv   (div_adv),
        .pre   (cfg_q.pre),
        .tc    (presc_tc)
    );

    rtick_modcnt #(
        .MOD_W (MOD_W)
    ) modc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_clr),
        .step  (presc_tc),
        .modv  (cfg_q.modv),
        .wrap  (period_end)
    );

    rtick_flag flag_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (period_end),
        .clr   (flag_clr),
        .q     (flag_o)
    );

    // Interrupt request follows the flag when enabled.
    always_comb irq_o = flag_o && ien_q;
endmodule

// File: rtl/rtick_timer_chk.sv
// Property checker for rtick_timer, attached with bind.
module rtick_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic       stat_wr,
    input logic       stat_wdata,
    input logic       wait_mode,
    input logic       wait_stop_en,
    input logic       pstop_mode,
    input logic       pstop_run_en,
    input logic       flag_o,
    input logic       irq_o,
    input logic       ien_q,
    input logic [2:0] cfg_pre,
    input logic       period_end
);
    a_r3_off_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pre == 3'd0) |=> !$rose(flag_o));

    a_r4_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !$rose(flag_o));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !(stat_wr && stat_wdata)) |=> flag_o);

    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && stat_wdata && !period_end) |=> !flag_o);

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> flag_o);

    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_o && ien_q));

    a_r9_wait_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_mode && wait_stop_en) |=> !$rose(flag_o));

    a_r10_pstop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (pstop_mode && !pstop_run_en) |=> !$rose(flag_o));
endmodule

bind rtick_timer rtick_timer_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .stat_wr      (stat_wr),
    .stat_wdata   (stat_wdata),
    .wait_mode    (wait_mode),
    .wait_stop_en (wait_stop_en),
    .pstop_mode   (pstop_mode),
    .pstop_run_en (pstop_run_en),
    .flag_o       (flag_o),
    .irq_o        (irq_o),
    .ien_q        (ien_q),
    .cfg_pre      (cfg_q.pre),
    .period_end   (period_end)
);

// File: tb/rtick_timer_tb_top.sv
`timescale 1ns/1ps
module rtick_timer_tb_top;
    localparam int unsigned EB    = 1;
    localparam int          NVEC  = 7;
    localparam int          LIMIT = 6000;

    // Setting under test and its period with EXP_BASE=1: (m+1)*2^(1+p).
    localparam logic [6:0] VEC_CFG [NVEC] = '{7'h10, 7'h1F, 7'h27, 7'h35, 7'h70, 7'h43, 7'h7F};
    localparam int         VEC_N   [NVEC] = '{4, 64, 64, 96, 256, 128, 4096};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       stat_wr = 1'b0;
    logic       stat_wdata = 1'b0;
    logic       ien_wr = 1'b0;
    logic       ien_wdata = 1'b0;
    logic       wait_mode = 1'b0;
    logic       wait_stop_en = 1'b0;
    logic       pstop_mode = 1'b0;
    logic       pstop_run_en = 1'b0;
    logic       flag_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rtick_timer #(.EXP_BASE(EB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .ien_wr(ien_wr),
        .ien_wdata(ien_wdata), .wait_mode(wait_mode), .wait_stop_en(wait_stop_en),
        .pstop_mode(pstop_mode), .pstop_run_en(pstop_run_en),
        .flag_o(flag_o), .irq_o(irq_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write a setting and clear the flag in the same cycle.
    task automatic wr_cfg(logic [6:0] v);
        cfg_wr = 1'b1; cfg_wdata = v; stat_wr = 1'b1; stat_wdata = 1'b1;
        tick();
        cfg_wr = 1'b0; stat_wr = 1'b0; stat_wdata = 1'b0;
    endtask

    task automatic clr_flag();
        stat_wr = 1'b1; stat_wdata = 1'b1;
        tick();
        stat_wr = 1'b0; stat_wdata = 1'b0;
    endtask

    // Cycles until the flag is seen; -1 if it never comes.
    task automatic cycles_to_flag(output int n);
        n = 0;
        while (!flag_o && n < LIMIT) begin
            tick();
            n++;
        end
        if (!flag_o) n = -1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        @(negedge clk);
        tick(); tick();
        check("R1 flag in reset", flag_o, 0);
        check("R1 irq in reset", irq_o, 0);
        rst_n = 1'b1;
        repeat (100) tick();
        check("R1 reset setting is off", flag_o, 0);

        // Table walk: period per setting, then back-to-back period.
        for (int i = 0; i < NVEC; i++) begin
            wr_cfg(VEC_CFG[i]);
            check("R6 flag cleared with write", flag_o, 0);
            cycles_to_flag(n);
            check($sformatf("R2 period cfg=%0h", VEC_CFG[i]), n, VEC_N[i]);
            clr_flag();
            cycles_to_flag(n);
            check($sformatf("R5 next period cfg=%0h", VEC_CFG[i]), n + 1, VEC_N[i]);
        end

        // R3: prescale code 0 stops the timer.
        wr_cfg(7'h05);
        repeat (300) tick();
        check("R3 off code no flag", flag_o, 0);

        // R4: rewrite mid-period restarts.
        wr_cfg(7'h13);
        repeat (10) tick();
        wr_cfg(7'h13);
        cycles_to_flag(n);
        check("R4 restart after rewrite", n, 16);
        // R4: rewrite in the period-end cycle discards that end.
        wr_cfg(7'h13);
        repeat (15) tick();
        wr_cfg(7'h13);
        check("R4 end in write cycle dropped", flag_o, 0);
        cycles_to_flag(n);
        check("R4 full period after drop", n, 16);

        // R6: write of 0 keeps the flag; write of 1 clears it.
        stat_wr = 1'b1; stat_wdata = 1'b0;
        tick();
        stat_wr = 1'b0;
        check("R6 write 0 no effect", flag_o, 1);
        // R8: interrupt follows flag and enable.
        check("R8 irq off with enable 0", irq_o, 0);
        ien_wr = 1'b1; ien_wdata = 1'b1;
        tick();
        ien_wr = 1'b0;
        check("R8 irq on", irq_o, 1);
        clr_flag();
        check("R6 write 1 clears", flag_o, 0);
        check("R8 irq drops with flag", irq_o, 0);

        // R7: clear in the period-end cycle loses to the set.
        wr_cfg(7'h13);
        cycles_to_flag(n);
        clr_flag();
        repeat (14) tick();
        stat_wr = 1'b1; stat_wdata = 1'b1;
        tick();
        stat_wr = 1'b0; stat_wdata = 1'b0;
        check("R7 set wins over clear", flag_o, 1);
        check("R8 irq with set flag", irq_o, 1);
        ien_wr = 1'b1; ien_wdata = 1'b0;
        tick();
        ien_wr = 1'b0;
        check("R8 irq masked", irq_o, 0);

        // R9: wait stop reinitialises; wait without stop runs.
        wr_cfg(7'h13);
        repeat (10) tick();
        wait_mode = 1'b1; wait_stop_en = 1'b1;
        repeat (40) tick();
        check("R9 halted in wait", flag_o, 0);
        wait_mode = 1'b0; wait_stop_en = 1'b0;
        cycles_to_flag(n);
        check("R9 full period after wait", n, 16);
        wait_mode = 1'b1;
        wr_cfg(7'h13);
        cycles_to_flag(n);
        check("R9 wait without stop runs", n, 16);
        wait_mode = 1'b0;

        // R10: pseudo-stop freezes and resumes; run option keeps counting.
        wr_cfg(7'h13);
        repeat (10) tick();
        pstop_mode = 1'b1;
        repeat (30) tick();
        check("R10 frozen in pseudo-stop", flag_o, 0);
        pstop_mode = 1'b0;
        cycles_to_flag(n);
        check("R10 resumes remainder", n, 6);
        pstop_mode = 1'b1; pstop_run_en = 1'b1;
        wr_cfg(7'h13);
        cycles_to_flag(n);
        check("R10 run option counts", n, 16);
        pstop_mode = 1'b0; pstop_run_en = 1'b0;

        // R1: reset clears a set flag and the setting.
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        check("R1 reset clears flag", flag_o, 0);
        repeat (100) tick();
        check("R1 setting off after reset", flag_o, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule